// File: doc/BRIEF.md
# Card Transfer Clock Pause Controller

This block decides, cycle by cycle, whether the divider that produces the serial clock of a memory-card host interface may issue pulses. It watches the occupancy of the receive and transmit data FIFOs and withdraws the clock one byte early. Receive is held one byte short of full, and transmit one byte short of empty, so the FIFO can never overrun or underrun while the last bit of a byte is still on the wire.

In a multiblock transfer, the command engine signals each block boundary with a strobe. The controller then parks the command sequence in a halted state until software decides what happens next:
- To continue a read, software writes both continue pulses in the same cycle.
- To continue a write, software writes the data-enable pulse.
- To end the sequence, software writes the abort pulse. It can then issue a stop-transmission command.

While a read is parked, the card clock stays off. A data-enable written while exactly one byte sits in the transmit FIFO is refused and reported as an error.

All control inputs are single-cycle write pulses. The clock-enable output is registered. A change on the inputs reaches it on the next rising edge of the system clock, so the divider only ever sees whole enable periods.

Top module: `card_clk_pause`

## Requirements
- R1: While reset is active, and on the first cycle after its release, `clk_en`, `seq_halted` and `den_err` are 0 and the sequence is idle.
- R2: A `seq_start` pulse in the idle state starts a sequence. From the next cycle `clk_en` is 1 unless a FIFO pause condition holds.
- R3: With `dir_rd`=1, `clk_en` is 0 in the cycle after any cycle in which `rx_level` is at least FIFO_DEPTH-1 (one byte short of full).
- R4: With `dir_rd`=0, `clk_en` is 0 in the cycle after any cycle in which `tx_level` is 0 or 1 (one byte or less from empty).
- R5: `clk_en` is a registered output. It reflects the levels and state of the previous cycle and reasserts on the first edge after a pause condition clears.
- R6: A `blk_end` pulse while running enters the halted state. `seq_halted` is 1 from the next cycle for the whole time the block waits at the boundary.
- R7: While halted with `dir_rd`=1, `clk_en` stays 0.
- R8: A halted read resumes only when `rd_conti_wr` and `data_en_wr` are both 1 in the same cycle and `rx_level` is at most FIFO_DEPTH-3. Otherwise both pulses are ignored and the block stays halted.
- R9: A halted write resumes on `data_en_wr`. While halted with `dir_rd`=0, `clk_en` follows the transmit pause rule of R4.
- R10: When `data_en_wr` is 1 with `dir_rd`=0 and `tx_level` equal to 1, `den_err` is 1 in the next cycle and the request has no effect on the state.
- R11: `cmd_abort_wr` returns the block to idle from any state. From the next cycle `clk_en` and `seq_halted` are 0. Abort takes priority over `blk_end`, `seq_start` and the continue pulses in the same cycle.
- R12: In the idle state, `blk_end`, `rd_conti_wr` and `data_en_wr` do not start a transfer: `clk_en` and `seq_halted` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_rd | input | 1 | Transfer direction, 1 = card to host |
| rx_level | input | LVL_W | Bytes held in the receive FIFO |
| tx_level | input | LVL_W | Bytes held in the transmit FIFO |
| seq_start | input | 1 | Pulse: command sequence begins |
| blk_end | input | 1 | Pulse: a block boundary has been reached |
| data_en_wr | input | 1 | Software write-one pulse: data enable |
| rd_conti_wr | input | 1 | Software write-one pulse: read continue |
| cmd_abort_wr | input | 1 | Software write-one pulse: abort the command sequence |
| clk_en | output | 1 | Enable for the card clock divider |
| seq_halted | output | 1 | Sequence is waiting at a block boundary |
| den_err | output | 1 | One-cycle flag: data enable refused with one byte left to send |

## Verification
Two pairs of functions can land in the same cycle. The first is the abort and a block boundary. The second is a continue request and a FIFO pause condition, where the resume and the pause meet on one edge.

The bench provokes the first pair directly, pulsing `cmd_abort_wr` together with `blk_end` and again together with a valid continue. It expects idle with the clock off, never halted.

For the second pair, it resumes a halted transfer while the levels sit at the pause threshold. It expects `seq_halted` to fall while `clk_en` stays 0.

A long random phase mixes all pulses with levels clustered around both thresholds. A behavioural model judges every cycle.

// File: rtl/card_clk_pause.sv
module card_clk_pause #(
  parameter int FIFO_DEPTH = 16,
  parameter int DRAIN_MIN  = 3,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             seq_start,
  input  logic             blk_end,
  input  logic             data_en_wr,
  input  logic             rd_conti_wr,
  input  logic             cmd_abort_wr,
  output logic             clk_en,
  output logic             seq_halted,
  output logic             den_err
);

  localparam logic [LVL_W-1:0] RX_NEAR_FULL = LVL_W'(FIFO_DEPTH - 1);
  localparam logic [LVL_W-1:0] RX_RESUME    = LVL_W'(FIFO_DEPTH - DRAIN_MIN);
  localparam logic [LVL_W-1:0] TX_LAST      = LVL_W'(1);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HALT = 2'd2} seq_t;

  seq_t st_q, st_n;
  logic clk_en_q, den_err_q;

  wire rx_pause   = dir_rd && (rx_level >= RX_NEAR_FULL);
  wire tx_pause   = !dir_rd && (tx_level <= TX_LAST);
  wire fifo_pause = rx_pause || tx_pause;
  wire tx_one     = !dir_rd && (tx_level == TX_LAST);
  wire rd_go      = dir_rd && rd_conti_wr && data_en_wr && (rx_level <= RX_RESUME);
  wire wr_go      = !dir_rd && data_en_wr && !tx_one;

  always_comb begin
    st_n = st_q;
    if (cmd_abort_wr) st_n = ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (seq_start)      st_n = ST_RUN;
        ST_RUN:  if (blk_end)        st_n = ST_HALT;
        ST_HALT: if (rd_go || wr_go) st_n = ST_RUN;
        default:                     st_n = ST_IDLE;
      endcase
    end
  end

  wire clk_on_n = ((st_n == ST_RUN) || (st_n == ST_HALT && !dir_rd)) && !fifo_pause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      clk_en_q  <= 1'b0;
      den_err_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      clk_en_q  <= clk_on_n;
      den_err_q <= data_en_wr && tx_one;
    end
  end

  assign clk_en     = clk_en_q;
  assign seq_halted = (st_q == ST_HALT);
  assign den_err    = den_err_q;

endmodule

module card_clk_pause_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_rd,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             blk_end,
  input logic             data_en_wr,
  input logic             rd_conti_wr,
  input logic             cmd_abort_wr,
  input logic             clk_en,
  input logic             seq_halted,
  input logic             den_err,
  input logic             running
);

  AST_RX_EARLY_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && rx_level >= LVL_W'(FIFO_DEPTH - 1)) |=> !clk_en); // R3

  AST_TX_EARLY_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && tx_level <= LVL_W'(1)) |=> !clk_en); // R4

  AST_BLOCK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (running && blk_end && !cmd_abort_wr) |=> seq_halted); // R6

  AST_RD_HALT_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_halted && dir_rd && !cmd_abort_wr && !(rd_conti_wr && data_en_wr)) |=> (seq_halted && !clk_en)); // R7

  AST_DEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en_wr && !dir_rd && tx_level == LVL_W'(1)) |=> den_err); // R10

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort_wr |=> (!clk_en && !seq_halted)); // R11

endmodule

bind card_clk_pause card_clk_pause_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .rx_level(rx_level), .tx_level(tx_level),
  .blk_end(blk_end), .data_en_wr(data_en_wr), .rd_conti_wr(rd_conti_wr),
  .cmd_abort_wr(cmd_abort_wr), .clk_en(clk_en), .seq_halted(seq_halted),
  .den_err(den_err), .running(st_q == ST_RUN)
);

// File: tb/card_clk_pause_test.sv
`timescale 1ns/1ps
module card_clk_pause_test;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_rd = 1'b1;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic seq_start = 0, blk_end = 0, data_en_wr = 0, rd_conti_wr = 0, cmd_abort_wr = 0;
  logic clk_en, seq_halted, den_err;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // model: 0 idle, 1 running, 2 halted
  int m_st = 0;
  bit m_clk = 0, m_err = 0;

  always #2.5 clk = ~clk;

  card_clk_pause #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .rx_level(rx_level), .tx_level(tx_level),
    .seq_start(seq_start), .blk_end(blk_end), .data_en_wr(data_en_wr),
    .rd_conti_wr(rd_conti_wr), .cmd_abort_wr(cmd_abort_wr),
    .clk_en(clk_en), .seq_halted(seq_halted), .den_err(den_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_clk = 0; m_err = 0;
    end else begin
      int lvl_rx, lvl_tx, nxt;
      bit paused;
      lvl_rx = rx_level; lvl_tx = tx_level;
      nxt = m_st;
      if (cmd_abort_wr) nxt = 0;
      else if (m_st == 0 && seq_start) nxt = 1;
      else if (m_st == 1 && blk_end) nxt = 2;
      else if (m_st == 2) begin
        if (dir_rd && rd_conti_wr && data_en_wr && lvl_rx <= DEPTH - 3) nxt = 1;
        if (!dir_rd && data_en_wr && lvl_tx != 1) nxt = 1;
      end
      paused = dir_rd ? (lvl_rx >= DEPTH - 1) : (lvl_tx <= 1);
      m_err = data_en_wr && !dir_rd && lvl_tx == 1;
      m_clk = !paused && (nxt == 1 || (nxt == 2 && !dir_rd));
      m_st = nxt;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("clk_en", clk_en, m_clk);
    check("seq_halted", seq_halted, m_st == 2);
    check("den_err", den_err, m_err);
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      seq_start = 0; blk_end = 0; data_en_wr = 0; rd_conti_wr = 0; cmd_abort_wr = 0;
    end
  endtask

  task automatic drive_pulse(input bit st, input bit be, input bit de, input bit rc, input bit ab);
    seq_start = st; blk_end = be; data_en_wr = de; rd_conti_wr = rc; cmd_abort_wr = ab;
    step();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    #12;
    check("reset clk_en", clk_en, 0);
    check("reset seq_halted", seq_halted, 0);
    check("reset den_err", den_err, 0);
    @(negedge clk); #1; rst_n = 1;
    step(2);

    cur_req = "R12";
    drive_pulse(0, 1, 1, 1, 0); step(2);
    check("idle stays off", clk_en, 0);

    cur_req = "R2"; dir_rd = 1; rx_level = 4;
    drive_pulse(1, 0, 0, 0, 0); step(2);
    check("started", clk_en, 1);

    cur_req = "R3";
    for (int l = 10; l <= DEPTH; l++) begin rx_level = LW'(l); step(); end
    cur_req = "R5"; rx_level = 14; step(3);

    cur_req = "R6"; drive_pulse(0, 1, 0, 0, 0); step(4);
    check("halted held", seq_halted, 1);
    cur_req = "R7"; rx_level = 5; step(3);
    cur_req = "R8"; rx_level = 15; drive_pulse(0, 0, 1, 1, 0);
    rx_level = 14; drive_pulse(0, 0, 1, 1, 0);
    rx_level = 13; drive_pulse(0, 0, 0, 1, 0); drive_pulse(0, 0, 1, 0, 0);
    check("still halted", seq_halted, 1);
    drive_pulse(0, 0, 1, 1, 0); step(2);
    check("resumed", clk_en, 1);

    cur_req = "R11";
    drive_pulse(0, 1, 0, 0, 1); step();
    check("abort beats boundary", seq_halted, 0);
    drive_pulse(1, 0, 0, 0, 0); drive_pulse(0, 1, 0, 0, 0);
    drive_pulse(0, 0, 1, 1, 1); step();
    check("abort beats continue", clk_en, 0);

    cur_req = "R4"; dir_rd = 0; tx_level = 8;
    drive_pulse(1, 0, 0, 0, 0);
    for (int l = 4; l >= 0; l--) begin tx_level = LW'(l); step(); end
    tx_level = 6; step(2);
    cur_req = "R9"; drive_pulse(0, 1, 0, 0, 0); step(3);
    cur_req = "R10"; tx_level = 1; drive_pulse(0, 0, 1, 0, 0); step();
    check("refused keeps halt", seq_halted, 1);
    cur_req = "R9"; tx_level = 7; drive_pulse(0, 0, 1, 0, 0); step(2);
    check("write resumed", clk_en, 1);
    cur_req = "R5"; tx_level = 2; drive_pulse(0, 1, 0, 0, 0); tx_level = 1;
    drive_pulse(0, 0, 0, 0, 0); tx_level = 0; drive_pulse(0, 0, 1, 0, 0); step(2);

    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      dir_rd = (i / 500) % 2;
      rx_level = LW'($urandom_range(DEPTH - 5, DEPTH));
      tx_level = LW'($urandom_range(0, 4));
      drive_pulse(r < 8, r >= 8 && r < 18, r >= 18 && r < 45, r >= 30 && r < 55, r >= 96);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule